// File: doc/BRIEF.md
# Next Fetch Address Predictor

This block supplies the address that instruction fetch should use after a given instruction slot. Each cycle it is given a lookup address and answers in the same cycle with a predicted next address. It also raises a flag when the prediction is a taken branch, which tells fetch to end the current fetch group there. Two tables produce the answer. One is a table of 2-bit saturating direction counters. The other is a direct-mapped branch target buffer, where each entry holds a valid bit, an address tag and a stored target.

A taken answer requires both tables to agree. The counter must say taken, and the target buffer must hold a valid entry whose tag matches the lookup address. In every other case the answer is the sequential address, four bytes on.

Branch resolution feeds the block through two update ports. One comes from the late resolution point (commit) and one from the early one (decode). Each update carries the branch address, its real direction and its correct next address. An update trains the counter and rewrites the target entry for that address.

Top module: `nxtpc_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and every target entry is invalid, so any lookup returns the lookup address plus 4 with the taken flag low.
- R2: When the prediction is not-taken, the next address is the lookup address plus 4 and the taken flag is 0.
- R3: When the counter for the lookup address is 2 or 3 and the target entry at its index is valid with a matching tag, the next address is the stored target and the taken flag is 1.
- R4: A target-buffer miss forces a not-taken prediction whatever the counter says. A miss is an invalid entry, or an entry whose tag (the address bits above the index) differs from the lookup's.
- R5: An update moves the counter indexed by address bits [DIR_IDX_W+1:2]. A taken update adds 1 and saturates at 3. A not-taken update subtracts 1 and saturates at 0.
- R6: Every update, taken or not, writes the target entry indexed by address bits [BTB_IDX_W+1:2]. It sets valid, stores the tag and overwrites the target with the supplied correct next address.
- R7: When both update ports are valid in the same cycle, only the commit-side update is applied and the decode-side update is lost.
- R8: An update on the decode-side port alone trains the tables the same way a commit-side update does.
- R9: Lookups are combinational on the table state. An update presented in a cycle affects lookups from the following cycle on, not the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Lookup address |
| lk_next_pc | output | 32 | Predicted next fetch address |
| lk_taken | output | 1 | Predicted-taken branch ends the fetch group |
| cm_upd_vld | input | 1 | Commit-side update valid |
| cm_upd_pc | input | 32 | Commit-side branch address |
| cm_upd_taken | input | 1 | Commit-side actual direction |
| cm_upd_tgt | input | 32 | Commit-side correct next address |
| dc_upd_vld | input | 1 | Decode-side update valid |
| dc_upd_pc | input | 32 | Decode-side branch address |
| dc_upd_taken | input | 1 | Decode-side actual direction |
| dc_upd_tgt | input | 32 | Decode-side correct next address |

## Verification
Internal state can be wrong in three ways, and each shows up at the ports on the first lookup of the affected address after the update edge:
- A counter that is off by one, or that fails to saturate, flips the taken flag. The tests drive counters to both rails and then step back one update to expose this.
- A bad tag compare lets an aliasing address borrow another branch's target. The alias test checks for this.
- A wrong arbitration choice leaves the dropped port's target visible. The same-cycle update test checks for this.

// File: rtl/nxtpc_pkg.sv
package nxtpc_pkg;
  localparam int ADDR_W = 32;
  typedef struct packed {
    logic              vld;
    logic              taken;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] tgt;
  } upd_t;
endpackage

// File: rtl/nxtpc_upd_arb.sv
module nxtpc_upd_arb
  import nxtpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  upd_t cm_upd,
  input  upd_t dc_upd,
  output upd_t sel_upd
);
  always_comb begin
    if (cm_upd.vld) sel_upd = cm_upd;
    else            sel_upd = dc_upd;
  end

  AST_CM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_upd.vld && dc_upd.vld) |-> (sel_upd.pc == cm_upd.pc && sel_upd.tgt == cm_upd.tgt)); // R7
  AST_DC_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cm_upd.vld && dc_upd.vld) |-> (sel_upd.vld && sel_upd.pc == dc_upd.pc)); // R8
endmodule

// File: rtl/nxtpc_dir_table.sv
module nxtpc_dir_table
  import nxtpc_pkg::*;
#(
  parameter int DIR_IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_taken,
  input  upd_t              wr_upd
);
  localparam int DEPTH = 1 << DIR_IDX_W;

  logic [1:0] ctr_q [DEPTH];
  logic [1:0] ctr_d [DEPTH];
  logic [DIR_IDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx   = rd_pc[DIR_IDX_W+1:2];
  assign wr_idx   = wr_upd.pc[DIR_IDX_W+1:2];
  assign rd_taken = ctr_q[rd_idx][1];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ctr_d[i] = ctr_q[i];
    if (wr_upd.vld) begin
      if (wr_upd.taken && ctr_q[wr_idx] != 2'b11)
        ctr_d[wr_idx] = ctr_q[wr_idx] + 2'b01;
      else if (!wr_upd.taken && ctr_q[wr_idx] != 2'b00)
        ctr_d[wr_idx] = ctr_q[wr_idx] - 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= 2'b01;
    end else if (wr_upd.vld) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= ctr_d[i];
    end
  end

  AST_TAKEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd.vld && wr_upd.taken) |=> (ctr_q[$past(wr_idx)] != 2'b00)); // R5
  AST_NT_NOT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd.vld && !wr_upd.taken) |=> (ctr_q[$past(wr_idx)] != 2'b11)); // R5
endmodule

// File: rtl/nxtpc_tgt_buf.sv
module nxtpc_tgt_buf
  import nxtpc_pkg::*;
#(
  parameter int BTB_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_tgt,
  input  upd_t              wr_upd
);
  localparam int DEPTH = 1 << BTB_IDX_W;
  localparam int TAG_W = ADDR_W - BTB_IDX_W - 2;

  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];
  logic [BTB_IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0]     rd_tag, wr_tag;

  assign rd_idx = rd_pc[BTB_IDX_W+1:2];
  assign rd_tag = rd_pc[ADDR_W-1:BTB_IDX_W+2];
  assign wr_idx = wr_upd.pc[BTB_IDX_W+1:2];
  assign wr_tag = wr_upd.pc[ADDR_W-1:BTB_IDX_W+2];

  assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_tgt = tgt_q[rd_idx];

  always_comb begin
    vld_d = vld_q;
    if (wr_upd.vld) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_upd.vld && (wr_idx == BTB_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (ent_we) begin
        tag_q[g] <= wr_tag;
        tgt_q[g] <= wr_upd.tgt;
      end
    end
  end

  AST_UPD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upd.vld |=> vld_q[$past(wr_idx)]); // R6
  AST_UPD_SELF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_upd.vld && rd_pc == $past(wr_upd.pc) && $past(wr_upd.vld)) |-> (rd_hit && rd_tgt == $past(wr_upd.tgt))); // R6
endmodule

// File: rtl/nxtpc_predictor.sv
module nxtpc_predictor
  import nxtpc_pkg::*;
#(
  parameter int DIR_IDX_W = 6,
  parameter int BTB_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_pc,
  output logic [31:0]       lk_next_pc,
  output logic              lk_taken,
  input  logic              cm_upd_vld,
  input  logic [31:0]       cm_upd_pc,
  input  logic              cm_upd_taken,
  input  logic [31:0]       cm_upd_tgt,
  input  logic              dc_upd_vld,
  input  logic [31:0]       dc_upd_pc,
  input  logic              dc_upd_taken,
  input  logic [31:0]       dc_upd_tgt
);
  localparam logic [ADDR_W-1:0] INST_BYTES = ADDR_W'(4);

  upd_t cm_upd, dc_upd, sel_upd;
  logic dir_taken, btb_hit;
  logic [ADDR_W-1:0] btb_tgt;

  assign cm_upd = '{vld: cm_upd_vld, taken: cm_upd_taken, pc: cm_upd_pc, tgt: cm_upd_tgt};
  assign dc_upd = '{vld: dc_upd_vld, taken: dc_upd_taken, pc: dc_upd_pc, tgt: dc_upd_tgt};

  nxtpc_upd_arb i_arb (
    .clk(clk), .rst_n(rst_n), .cm_upd(cm_upd), .dc_upd(dc_upd), .sel_upd(sel_upd)
  );

  nxtpc_dir_table #(.DIR_IDX_W(DIR_IDX_W)) i_dir (
    .clk(clk), .rst_n(rst_n), .rd_pc(lk_pc), .rd_taken(dir_taken), .wr_upd(sel_upd)
  );

  nxtpc_tgt_buf #(.BTB_IDX_W(BTB_IDX_W)) i_btb (
    .clk(clk), .rst_n(rst_n), .rd_pc(lk_pc), .rd_hit(btb_hit), .rd_tgt(btb_tgt),
    .wr_upd(sel_upd)
  );

  always_comb begin
    lk_taken   = dir_taken && btb_hit;
    lk_next_pc = lk_taken ? btb_tgt : (lk_pc + INST_BYTES);
  end

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> btb_hit); // R4
  AST_MISS_IS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    !btb_hit |-> (lk_next_pc == lk_pc + INST_BYTES)); // R2
endmodule

// File: tb/test_nxtpc_predictor.sv
module test_nxtpc_predictor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic [31:0] lk_next_pc;
  logic        lk_taken;
  logic        cm_upd_vld, cm_upd_taken, dc_upd_vld, dc_upd_taken;
  logic [31:0] cm_upd_pc, cm_upd_tgt, dc_upd_pc, dc_upd_tgt;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nxtpc_predictor i_nxtpc_predictor (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_next_pc(lk_next_pc), .lk_taken(lk_taken),
    .cm_upd_vld(cm_upd_vld), .cm_upd_pc(cm_upd_pc), .cm_upd_taken(cm_upd_taken),
    .cm_upd_tgt(cm_upd_tgt), .dc_upd_vld(dc_upd_vld), .dc_upd_pc(dc_upd_pc),
    .dc_upd_taken(dc_upd_taken), .dc_upd_tgt(dc_upd_tgt)
  );

  task automatic look(input logic [31:0] pc, input logic [31:0] exp_pc,
                      input logic exp_tk, input string req);
    lk_pc = pc;
    #1;
    n_vec++;
    if (lk_next_pc !== exp_pc || lk_taken !== exp_tk) begin
      n_fail++;
      $display("FAIL %s pc=%h next=%h taken=%b expected next=%h taken=%b",
               req, pc, lk_next_pc, lk_taken, exp_pc, exp_tk);
    end
  endtask

  task automatic upd(input logic cv, input logic [31:0] cpc, input logic ct, input logic [31:0] ctg,
                     input logic dv, input logic [31:0] dpc, input logic dt, input logic [31:0] dtg);
    @(negedge clk);
    cm_upd_vld = cv; cm_upd_pc = cpc; cm_upd_taken = ct; cm_upd_tgt = ctg;
    dc_upd_vld = dv; dc_upd_pc = dpc; dc_upd_taken = dt; dc_upd_tgt = dtg;
    @(negedge clk);
    cm_upd_vld = 1'b0; dc_upd_vld = 1'b0;
  endtask

  task automatic t_reset;
    look(32'h0000_1040, 32'h0000_1044, 1'b0, "R1");
    look(32'h0000_2008, 32'h0000_200C, 1'b0, "R1");
    look(32'hFFFF_FFF0, 32'hFFFF_FFF4, 1'b0, "R1");
  endtask

  task automatic t_train_taken;
    // R9: same-cycle lookup does not see the pending update
    @(negedge clk);
    cm_upd_vld = 1'b1; cm_upd_pc = 32'h1040; cm_upd_taken = 1'b1; cm_upd_tgt = 32'h9000;
    look(32'h1040, 32'h1044, 1'b0, "R9");
    @(negedge clk);
    cm_upd_vld = 1'b0;
    look(32'h1040, 32'h9000, 1'b1, "R3");
  endtask

  task automatic t_train_not_taken;
    upd(1, 32'h1040, 0, 32'h1044, 0, 0, 0, 0);
    look(32'h1040, 32'h1044, 1'b0, "R2");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 3; i++) upd(1, 32'h1040, 1, 32'h9100, 0, 0, 0, 0);
    upd(1, 32'h1040, 0, 32'h9200, 0, 0, 0, 0);
    look(32'h1040, 32'h9200, 1'b1, "R5 high saturation / R6 overwrite");
    for (int i = 0; i < 4; i++) upd(1, 32'h1040, 0, 32'h9250, 0, 0, 0, 0);
    upd(1, 32'h1040, 1, 32'h9300, 0, 0, 0, 0);
    look(32'h1040, 32'h1044, 1'b0, "R5 low saturation");
  endtask

  task automatic t_alias;
    upd(1, 32'h1080, 1, 32'hA000, 0, 0, 0, 0);
    look(32'h1080, 32'hA000, 1'b1, "R3 alias setup");
    upd(1, 32'h1040, 1, 32'hB000, 0, 0, 0, 0);
    look(32'h1040, 32'hB000, 1'b1, "R6 tag replace");
    look(32'h1080, 32'h1084, 1'b0, "R4 tag mismatch");
  endtask

  task automatic t_both_ports;
    upd(1, 32'h2008, 1, 32'hC000, 1, 32'h200C, 1, 32'hD000);
    look(32'h2008, 32'hC000, 1'b1, "R7 commit applied");
    look(32'h200C, 32'h2010, 1'b0, "R7 decode dropped");
    upd(1, 32'h4014, 1, 32'h5000, 1, 32'h4014, 1, 32'h6000);
    look(32'h4014, 32'h5000, 1'b1, "R7 same pc commit target");
  endtask

  task automatic t_decode_only;
    upd(0, 0, 0, 0, 1, 32'h3010, 1, 32'hE000);
    look(32'h3010, 32'hE000, 1'b1, "R8");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_pc = '0;
    cm_upd_vld = 0; cm_upd_pc = '0; cm_upd_taken = 0; cm_upd_tgt = '0;
    dc_upd_vld = 0; dc_upd_pc = '0; dc_upd_taken = 0; dc_upd_tgt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_train_taken();
    t_train_not_taken();
    t_saturate();
    t_alias();
    t_both_ports();
    t_decode_only();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule